// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Flow Control

This block is the send half of an asynchronous serial controller. A host writes one character at a time into a single holding register. When transmission is allowed, the character moves into a shift engine. The engine drives the serial line with a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then a high stop period. Bit timing comes from a separate, slower transmit clock. That clock is synchronised into the system clock domain, and each of its falling edges becomes a one-cycle tick. A bit lasts 1, 16 or 64 ticks.

Two flags tell the host what it may do. A ready output says the host may write now, and it also requires the remote side's clear-to-send (active low) and the local enable command. A buffer-free status bit reports only that the holding register is empty. An empty output says that nothing is held and nothing is being shifted. Enable and clear-to-send are looked at only when a new character would start, so a character already in the shift engine always completes. A break command pulls the line low for as long as it is set.

Top module: `uart_async_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1 and `tx_buf_free` is 1; with `tx_en`=1 and `cts_n`=0, `tx_rdy_pin` is also 1.
- R2: A frame is one start tick period at 0, then the data bits least significant first, with the count set by `len_sel` (00=5, 01=6, 10=7, 11=8). If `par_en`=1, a parity bit follows; it makes the count of ones over data and parity even when `par_odd`=0 and odd when `par_odd`=1. The frame ends with a stop period at 1.
- R3: A tick is a falling edge of `tx_clk_in`. Each start, data and parity bit lasts 1 tick for `rate_sel`=00 or 01, 16 ticks for 10 and 64 ticks for 11. The line changes only on a tick.
- R4: The stop period lasts one bit time for `stop_sel`=00 or 01 and two bit times for 11. For 10 it lasts one and a half bit times: 24 ticks at ×16, 96 ticks at ×64, and 2 ticks at ×1.
- R5: `tx_rdy_pin` is 1 only when `cts_n`=0, `tx_en`=1 and the holding register is free. `tx_buf_free` ignores `cts_n` and `tx_en`.
- R6: During the cycle in which `wr_stb` is 1, both `tx_buf_free` and `tx_empty` read 0.
- R7: `tx_empty` is 1 exactly when the holding register is empty and no frame is being sent; the line is then 1 unless a break is commanded.
- R8: Clearing `tx_en` or raising `cts_n` does not cut a frame in progress. A character written while sending is blocked stays held, with the line at 1, until sending is allowed again.
- R9: While `send_break` is 1, `txd` is 0.
- R10: If a character is held and sending is allowed when a stop period ends, its start bit begins on that same tick, with no idle tick between the frames.
- R11: A write while the holding register is full replaces the held character; only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_in | input | 1 | Transmit bit clock, asynchronous to clk |
| wr_stb | input | 1 | One-cycle write strobe for a character |
| wr_data | input | 8 | Character to send |
| len_sel | input | 2 | Character length select (5 + value) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stop_sel | input | 2 | Stop length: 00/01 one, 10 one and a half, 11 two |
| rate_sel | input | 2 | Ticks per bit: 00/01 ×1, 10 ×16, 11 ×64 |
| tx_en | input | 1 | Transmit enable command |
| send_break | input | 1 | Break command, forces the line low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output line |
| tx_rdy_pin | output | 1 | Ready pin, gated by flow control |
| tx_buf_free | output | 1 | Status bit: holding register empty |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
The assertions assume that `wr_stb` is a pulse of one cycle. They also assume that `tx_clk_in` runs well below the system clock, so that ticks are spaced far apart. The mode fields must stay constant while a character could be loaded, since they are captured at load. The stimulus drives the transmit clock with a period of 32 system cycles. It changes the mode fields and `wr_data` only at falling system edges while the transmitter is idle. Writes come from a task that always produces single-cycle strobes.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 8;
    localparam int BITCNT_W = 4;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_sel;
        logic [1:0] rate_sel;
    } txmode_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BITS = 2'd1,
        PH_STOP = 2'd2
    } phase_e;

    function automatic logic [CNT_W-1:0] ticks_per_bit(input logic [1:0] rate);
        case (rate)
            2'b10:   ticks_per_bit = CNT_W'(16);
            2'b11:   ticks_per_bit = CNT_W'(64);
            default: ticks_per_bit = CNT_W'(1);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] rate,
                                                    input logic [1:0] stop);
        logic [CNT_W-1:0] f;
        f = ticks_per_bit(rate);
        case (stop)
            2'b10:   stop_ticks = (f == CNT_W'(1)) ? CNT_W'(2) : f + (f >> 1);
            2'b11:   stop_ticks = f << 1;
            default: stop_ticks = f;
        endcase
    endfunction

    function automatic logic [BITCNT_W-1:0] char_bits(input logic [1:0] len_sel);
        char_bits = BITCNT_W'(5) + BITCNT_W'(len_sel);
    endfunction

    // data bits in the low positions, parity bit just above the last data bit
    function automatic logic [DATA_W:0] pack_char(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] len_sel,
                                                  input logic par_odd);
        logic [DATA_W:0]      pk;
        logic                 p;
        logic [BITCNT_W-1:0]  n;
        n  = char_bits(len_sel);
        pk = '0;
        p  = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (BITCNT_W'(i) < n) begin
                pk[i] = d[i];
                p     = p ^ d[i];
            end
        end
        pk[n] = p;
        pack_char = pk;
    endfunction

endpackage

// File: rtl/uatx_tick.sv
module uatx_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_clk,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= async_clk;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign tick = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uatx_hold.sv
module uatx_hold
    import uatx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uatx_shift.sv
module uatx_shift
    import uatx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_ok,
    input  logic [DATA_W-1:0] hold_data,
    input  txmode_t           mode,
    output logic              take,
    output logic              busy,
    output logic              line
);
    phase_e               ph_q;
    logic [DATA_W:0]      shreg_q;
    logic [BITCNT_W-1:0]  left_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     fac_q;
    logic [CNT_W-1:0]     stop_q;
    logic                 frame_end;
    logic [CNT_W-1:0]     new_fac;

    assign frame_end = (ph_q == PH_STOP) && (cnt_q == '0);
    assign take      = tick && load_ok && ((ph_q == PH_IDLE) || frame_end);
    assign busy      = (ph_q != PH_IDLE);
    assign new_fac   = ticks_per_bit(mode.rate_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
            cnt_q   <= '0;
            fac_q   <= CNT_W'(1);
            stop_q  <= CNT_W'(1);
            line    <= 1'b1;
        end else if (take) begin
            ph_q    <= PH_BITS;
            shreg_q <= pack_char(hold_data, mode.len_sel, mode.par_odd);
            left_q  <= char_bits(mode.len_sel) + BITCNT_W'(mode.par_en);
            fac_q   <= new_fac;
            cnt_q   <= new_fac - CNT_W'(1);
            stop_q  <= stop_ticks(mode.rate_sel, mode.stop_sel);
            line    <= 1'b0;
        end else if (tick) begin
            case (ph_q)
                PH_BITS: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (left_q != '0) begin
                        line    <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        left_q  <= left_q - BITCNT_W'(1);
                        cnt_q   <= fac_q - CNT_W'(1);
                    end else begin
                        line  <= 1'b1;
                        ph_q  <= PH_STOP;
                        cnt_q <= stop_q - CNT_W'(1);
                    end
                end
                PH_STOP: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                    else             ph_q  <= PH_IDLE;
                end
                default: line <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uart_async_tx.sv
module uart_async_tx
    import uatx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_clk_in,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic [1:0]        rate_sel,
    input  logic              tx_en,
    input  logic              send_break,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_rdy_pin,
    output logic              tx_buf_free,
    output logic              tx_empty
);
    txmode_t           mode_w;
    logic              tick_w;
    logic              full_w;
    logic [DATA_W-1:0] held_w;
    logic              take_w;
    logic              busy_w;
    logic              line_w;
    logic              go_w;

    assign mode_w = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd,
                      stop_sel: stop_sel, rate_sel: rate_sel};
    assign go_w   = tx_en & ~cts_n;

    uatx_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst(rst), .async_clk(tx_clk_in), .tick(tick_w)
    );

    uatx_hold u_hold (
        .clk(clk), .rst(rst), .wr(wr_stb), .wdata(wr_data),
        .take(take_w), .full(full_w), .data(held_w)
    );

    uatx_shift u_shift (
        .clk(clk), .rst(rst), .tick(tick_w), .load_ok(full_w & go_w),
        .hold_data(held_w), .mode(mode_w),
        .take(take_w), .busy(busy_w), .line(line_w)
    );

    assign txd         = send_break ? 1'b0 : line_w;
    assign tx_buf_free = ~full_w & ~wr_stb;
    assign tx_rdy_pin  = go_w & tx_buf_free;
    assign tx_empty    = ~full_w & ~busy_w & ~wr_stb;

endmodule

// File: rtl/uatx_checks.sv
module uatx_checks (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic cts_n,
    input logic tx_en,
    input logic send_break,
    input logic txd,
    input logic tx_rdy_pin,
    input logic tx_buf_free,
    input logic tx_empty,
    input logic tick,
    input logic line
);
    a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
        send_break |-> !txd);

    a_r5_pin_gated: assert property (@(posedge clk) disable iff (rst)
        tx_rdy_pin |-> (!cts_n && tx_en && tx_buf_free));

    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (!tx_buf_free && !tx_empty));

    a_r7_empty_means_free: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_buf_free);

    a_r7_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !send_break) |-> txd);

    a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (line != $past(line)) |-> $past(tick));
endmodule

bind uart_async_tx uatx_checks u_chk (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .cts_n(cts_n), .tx_en(tx_en),
    .send_break(send_break), .txd(txd), .tx_rdy_pin(tx_rdy_pin),
    .tx_buf_free(tx_buf_free), .tx_empty(tx_empty),
    .tick(tick_w), .line(line_w)
);

// File: tb/uart_async_tx_bench.sv
module uart_async_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TXC_HALF   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_clk_in = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_sel = 2'b01;
    logic [1:0] rate_sel = 2'b10;
    logic       tx_en = 1'b1;
    logic       send_break = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd, tx_rdy_pin, tx_buf_free, tx_empty;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic exp_bits [0:2047];
    int   exp_n;

    uart_async_tx u_uart_async_tx (
        .clk(clk), .rst(rst), .tx_clk_in(tx_clk_in), .wr_stb(wr_stb),
        .wr_data(wr_data), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .stop_sel(stop_sel), .rate_sel(rate_sel), .tx_en(tx_en),
        .send_break(send_break), .cts_n(cts_n), .txd(txd),
        .tx_rdy_pin(tx_rdy_pin), .tx_buf_free(tx_buf_free), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always begin
        repeat (TXC_HALF) @(negedge clk);
        tx_clk_in = ~tx_clk_in;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_fac(input logic [1:0] r);
        if (r == 2'b10) return 16;
        if (r == 2'b11) return 64;
        return 1;
    endfunction

    function automatic int ref_stop(input logic [1:0] r, input logic [1:0] s);
        int f = ref_fac(r);
        if (s == 2'b11) return 2 * f;
        if (s == 2'b10) return (f == 1) ? 2 : (3 * f) / 2;
        return f;
    endfunction

    task automatic push(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            exp_bits[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic add_frame(input logic [7:0] d);
        int f = ref_fac(rate_sel);
        int nb = 5 + int'(len_sel);
        logic p = par_odd;
        push(1'b0, f);
        for (int k = 0; k < nb; k++) begin
            push(d[k], f);
            p = p ^ d[k];
        end
        if (par_en) push(p, f);
        push(1'b1, ref_stop(rate_sel, stop_sel));
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // samples the line once per tick, half a transmit period after the tick
    task automatic capture(input string req);
        int guard = 0;
        int bad = -1;
        logic got = 1'b0;
        do begin
            @(posedge tx_clk_in);
            guard++;
        end while (txd !== 1'b0 && guard < 3000);
        if (guard >= 3000) begin
            check(0, req, 1, 0);
            return;
        end
        for (int i = 1; i < exp_n + 2; i++) begin
            @(posedge tx_clk_in);
            if (bad < 0) begin
                logic e = (i < exp_n) ? exp_bits[i] : 1'b1;
                if (txd !== e) begin
                    bad = i;
                    got = txd;
                end
            end
        end
        if (bad >= 0) check(0, $sformatf("%s tick %0d", req, bad), int'(got), int'(~got));
        else          check(1, req, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h2468);
        repeat (8) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(txd === 1'b1, "R1 txd", int'(txd), 1);
        check(tx_empty === 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        check(tx_buf_free === 1'b1, "R1 tx_buf_free", int'(tx_buf_free), 1);
        check(tx_rdy_pin === 1'b1, "R1 tx_rdy_pin", int'(tx_rdy_pin), 1);

        // R5 flow control gates only the pin
        cts_n = 1'b1; #1;
        check(tx_rdy_pin === 1'b0, "R5 pin with cts high", int'(tx_rdy_pin), 0);
        check(tx_buf_free === 1'b1, "R5 status with cts high", int'(tx_buf_free), 1);
        cts_n = 1'b0; tx_en = 1'b0; #1;
        check(tx_rdy_pin === 1'b0, "R5 pin while disabled", int'(tx_rdy_pin), 0);
        tx_en = 1'b1;

        // R9 break
        @(negedge clk); send_break = 1'b1; #1;
        check(txd === 1'b0, "R9 break low", int'(txd), 0);
        @(negedge clk); send_break = 1'b0; #1;
        check(txd === 1'b1, "R9 break released", int'(txd), 1);

        // R6 write strobe clears flags in its own cycle
        tx_en = 1'b0;
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'hA5; #1;
        check(tx_buf_free === 1'b0, "R6 free during strobe", int'(tx_buf_free), 0);
        check(tx_empty === 1'b0, "R6 empty during strobe", int'(tx_empty), 0);
        @(negedge clk); wr_stb = 1'b0;

        // R11 overwrite while held, R8 held while disabled
        write_char(8'h3C);
        repeat (20) @(posedge tx_clk_in);
        check(txd === 1'b1, "R8 held char not sent", int'(txd), 1);
        check(tx_empty === 1'b0, "R7 not empty with held char", int'(tx_empty), 0);
        len_sel = 2'b11; par_en = 1'b0; stop_sel = 2'b01; rate_sel = 2'b10;
        exp_n = 0; add_frame(8'h3C);
        @(negedge clk); tx_en = 1'b1;
        capture("R11 last write sent");
        check(tx_empty === 1'b1, "R7 empty after frame", int'(tx_empty), 1);

        // R8 disable mid-frame, then a write while disabled
        len_sel = 2'b10; par_en = 1'b1; par_odd = 1'b1; stop_sel = 2'b11;
        exp_n = 0; add_frame(8'h5B);
        fork
            capture("R8 frame completes after disable");
            begin
                write_char(8'h5B);
                wait (txd === 1'b0);
                @(negedge clk); cts_n = 1'b1; tx_en = 1'b0;
            end
        join
        write_char(8'h96);
        for (int i = 0; i < 30; i++) begin
            @(posedge tx_clk_in);
            if (txd !== 1'b1) begin
                check(0, "R8 line idle while disabled", int'(txd), 1);
                break;
            end
        end
        check(tx_buf_free === 1'b0, "R8 char still held", int'(tx_buf_free), 0);
        exp_n = 0; add_frame(8'h96);
        @(negedge clk); cts_n = 1'b0; tx_en = 1'b1;
        capture("R8 held char after re-enable");

        // R3 x64 rate, R2 shortest character
        len_sel = 2'b00; par_en = 1'b0; stop_sel = 2'b01; rate_sel = 2'b11;
        exp_n = 0; add_frame(8'h13);
        fork
            capture("R3 x64 frame");
            write_char(8'h13);
        join

        // R4 one and a half stops at x16, back-to-back R10
        len_sel = 2'b01; par_en = 1'b1; par_odd = 1'b0; stop_sel = 2'b10; rate_sel = 2'b10;
        exp_n = 0; add_frame(8'h2E); add_frame(8'h11);
        fork
            capture("R4 R10 1.5 stop pair");
            begin
                write_char(8'h2E);
                wait (tx_buf_free === 1'b1);
                write_char(8'h11);
            end
        join

        // R2 R4 R10 random pairs at x1 and x16
        for (int n = 0; n < 6; n++) begin
            logic [7:0] a = 8'($urandom);
            logic [7:0] b = 8'($urandom);
            len_sel  = 2'($urandom);
            par_en   = 1'($urandom);
            par_odd  = 1'($urandom);
            stop_sel = 2'($urandom);
            rate_sel = 2'($urandom_range(0, 2));
            exp_n = 0; add_frame(a); add_frame(b);
            fork
                capture($sformatf("R2 R4 R10 random pair %0d", n));
                begin
                    write_char(a);
                    wait (tx_buf_free === 1'b1);
                    write_char(b);
                end
            join
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule